// File: doc/BRIEF.md
# Saturating Fixed-Point Arithmetic Unit

This block is a one-stage registered arithmetic unit for two's-complement words of `DATA_W` bits, 32 by default, which is the Q31 range. It performs signed addition, signed subtraction, negation, arithmetic left shift, arithmetic right shift, a count of redundant sign bits and an unsigned addition. Each operation finds overflow with a rule of its own.

When the saturate input is high, an out-of-range result is clamped to a limit. For signed operations the limit is the largest positive value or the most negative value. For the unsigned add it is all ones. When the saturate input is low, the result wraps. In both cases the overflow output reports that the exact result did not fit.

Software uses the sign-bit count to learn how far a value can be shifted left before any bits are lost. The unit handles one operation per cycle. An operation presented with `in_valid` appears on the outputs one clock later.

Top module: `sat_alu`

## Requirements
- R1: Reset (active-low `rst_n`) clears `out_valid`, `result` and `ovf` to zero. An operation accepted with `in_valid` high appears on the outputs at the next rising edge, with `out_valid` high for that one cycle. While `in_valid` is low, `out_valid` is low and `result` and `ovf` hold their previous values.
- R2: Opcode 0 is signed add. It can overflow only when both operands have the same sign. A saturated result is 0x7FFFFFFF for a positive overflow and 0x80000000 for a negative overflow.
- R3: Opcode 1 is signed subtract (`a - b`). It can overflow only when the operands have opposite signs. A saturated result takes the sign of `a`.
- R4: Opcode 2 negates `a`. Only 0x80000000 overflows. Its saturated result is 0x7FFFFFFF and its wrapped result is 0x80000000.
- R5: Opcode 3 shifts `a` left by `shamt`. It overflows when any significant bit would be lost, which is when shifting the result back arithmetically does not give `a`. A saturated result is 0x7FFFFFFF if `a` is non-negative and 0x80000000 if `a` is negative.
- R6: Opcode 4 shifts `a` right arithmetically by `shamt`. It never overflows.
- R7: With `shamt` equal to 0, both shift opcodes return `a` unchanged and do not flag overflow.
- R8: Opcode 5 returns, zero-extended, the number of bits below the sign bit that equal the sign bit, counted downward until the first bit that differs. This is the largest left shift that does not overflow. The count is 31 for 0 and for 0xFFFFFFFF. It never flags overflow.
- R9: Opcode 6 is an unsigned add. A carry out of the top bit is an overflow, and a saturated result is 0xFFFFFFFF.
- R10: `ovf` is high whenever the exact result is out of range, whatever the value of `sat_en`. With `sat_en` low, the result is the wrapped value.
- R11: Opcode 7 is reserved and returns a result of 0 with `ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| a | input | DATA_W | First operand |
| b | input | DATA_W | Second operand |
| shamt | input | $clog2(DATA_W) | Shift distance |
| out_valid | output | 1 | Result valid |
| result | output | DATA_W | Operation result |
| ovf | output | 1 | Exact result was out of range |

## Verification
The bench builds the unit with its default 32-bit width, so the shift distance spans 0 to 31. With that width the exact boundary words can be hand-checked: 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. The bench covers each overflow rule at its edge, with saturation enabled and with it disabled. It also covers the sign-bit count at both extremes and at midway values.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
    typedef enum logic [2:0] {
        OPC_ADD  = 3'd0,
        OPC_SUB  = 3'd1,
        OPC_NEG  = 3'd2,
        OPC_SHL  = 3'd3,
        OPC_SHR  = 3'd4,
        OPC_CLS  = 3'd5,
        OPC_ADDU = 3'd6,
        OPC_RSVD = 3'd7
    } alu_opc_e;
endpackage

// File: rtl/sat_alu_addsub.sv
module sat_alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] add_res,
    output logic              add_ovf,
    output logic [DATA_W-1:0] sub_res,
    output logic              sub_ovf,
    output logic [DATA_W-1:0] neg_res,
    output logic              neg_ovf,
    output logic [DATA_W-1:0] addu_res,
    output logic              addu_ovf
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W:0] wide_u;

    always_comb begin
        add_res  = a + b;
        add_ovf  = (a[MSB] == b[MSB]) && (add_res[MSB] != a[MSB]);

        sub_res  = a - b;
        sub_ovf  = (a[MSB] != b[MSB]) && (sub_res[MSB] != a[MSB]);

        neg_res  = (~a) + 1'b1;
        neg_ovf  = (a == MOST_NEG);

        wide_u   = {1'b0, a} + {1'b0, b};
        addu_res = wide_u[DATA_W-1:0];
        addu_ovf = wide_u[DATA_W];
    end
endmodule

// File: rtl/sat_alu_shift.sv
module sat_alu_shift #(
    parameter int DATA_W = 32,
    localparam int SH_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] shl_res,
    output logic              shl_ovf,
    output logic [DATA_W-1:0] shr_res
);
    logic [DATA_W-1:0] undo;

    always_comb begin
        shl_res = a << shamt;
        undo    = $unsigned($signed(shl_res) >>> shamt);
        shl_ovf = (undo != a);
        shr_res = $unsigned($signed(a) >>> shamt);
    end
endmodule

// File: rtl/sat_alu_cls.sv
module sat_alu_cls #(
    parameter int DATA_W = 32,
    localparam int SH_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    output logic [SH_W-1:0]   count
);
    logic stop;

    always_comb begin
        count = '0;
        stop  = 1'b0;
        for (int i = DATA_W - 2; i >= 0; i--) begin
            if (!stop && (a[i] == a[DATA_W-1])) begin
                count = count + 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
    parameter int DATA_W = 32,
    localparam int SH_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic              sat_en,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SH_W-1:0]   shamt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);
    import sat_alu_pkg::*;

    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] U_LIM   = {DATA_W{1'b1}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              ovf;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [DATA_W-1:0] add_res, sub_res, neg_res, addu_res, shl_res, shr_res;
    logic              add_ovf, sub_ovf, neg_ovf, addu_ovf, shl_ovf;
    logic [SH_W-1:0]   cls_cnt;

    logic [DATA_W-1:0] wrap_val, clamp_val;
    logic              hit_ovf;
    alu_opc_e          opc;

    sat_alu_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a        (a),
        .b        (b),
        .add_res  (add_res),
        .add_ovf  (add_ovf),
        .sub_res  (sub_res),
        .sub_ovf  (sub_ovf),
        .neg_res  (neg_res),
        .neg_ovf  (neg_ovf),
        .addu_res (addu_res),
        .addu_ovf (addu_ovf)
    );

    sat_alu_shift #(.DATA_W(DATA_W)) shift_i (
        .a       (a),
        .shamt   (shamt),
        .shl_res (shl_res),
        .shl_ovf (shl_ovf),
        .shr_res (shr_res)
    );

    sat_alu_cls #(.DATA_W(DATA_W)) cls_i (
        .a     (a),
        .count (cls_cnt)
    );

    always_comb begin
        opc       = alu_opc_e'(op);
        wrap_val  = '0;
        hit_ovf   = 1'b0;
        clamp_val = a[DATA_W-1] ? NEG_LIM : POS_LIM;
        unique case (opc)
            OPC_ADD:  begin wrap_val = add_res;  hit_ovf = add_ovf;  end
            OPC_SUB:  begin wrap_val = sub_res;  hit_ovf = sub_ovf;  end
            OPC_NEG:  begin wrap_val = neg_res;  hit_ovf = neg_ovf;
                            clamp_val = POS_LIM; end
            OPC_SHL:  begin wrap_val = shl_res;  hit_ovf = shl_ovf;  end
            OPC_SHR:  begin wrap_val = shr_res;  end
            OPC_CLS:  begin wrap_val = {{(DATA_W-SH_W){1'b0}}, cls_cnt}; end
            OPC_ADDU: begin wrap_val = addu_res; hit_ovf = addu_ovf;
                            clamp_val = U_LIM; end
            default:  begin wrap_val = '0; end
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ovf = hit_ovf;
            st_d.res = (sat_en && hit_ovf) ? clamp_val : wrap_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign ovf       = st_q.ovf;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
    parameter int DATA_W = 32,
    localparam int SH_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic              sat_en,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [SH_W-1:0]   shamt,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              ovf
);
    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    // R1
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(ovf)));

    // R2
    add_mixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && a[DATA_W-1] != b[DATA_W-1]) |=> !ovf);

    // R3
    sub_same_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1 && a[DATA_W-1] == b[DATA_W-1]) |=> !ovf);

    // R2
    signed_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && (op == 3'd0 || op == 3'd1 || op == 3'd2 || op == 3'd3))
        |=> (!ovf || result == POS_LIM || result == NEG_LIM));

    // R6
    shr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=> !ovf);

    // R7
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd3 || op == 3'd4) && shamt == '0)
        |=> (!ovf && result == $past(a)));

    // R8
    cls_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd5) |=> (!ovf && result <= DATA_W - 1));

    // R9
    addu_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && op == 3'd6) |=> (!ovf || result == {DATA_W{1'b1}}));

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7) |=> (!ovf && result == '0));
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .sat_en    (sat_en),
    .a         (a),
    .b         (b),
    .shamt     (shamt),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/sat_alu_tb_top.sv
`timescale 1ns/1ps
module sat_alu_tb_top;
    localparam int DW = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    op = '0;
    logic          sat_en = 1'b0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic [SW-1:0] shamt = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          ovf;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sat_alu #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .sat_en(sat_en),
        .a(a), .b(b), .shamt(shamt), .out_valid(out_valid), .result(result), .ovf(ovf)
    );

    task automatic check(input string tag, input logic [DW-1:0] exp_r, input logic exp_o,
                         input logic exp_v);
        checks++;
        if (result !== exp_r || ovf !== exp_o || out_valid !== exp_v) begin
            fails++;
            $display("FAIL %s: got res=%h ovf=%b vld=%b expected res=%h ovf=%b vld=%b",
                     tag, result, ovf, out_valid, exp_r, exp_o, exp_v);
        end
    endtask

    task automatic issue(input string tag, input logic [2:0] o, input logic s,
                         input logic [DW-1:0] x, input logic [DW-1:0] y,
                         input logic [SW-1:0] sh, input logic [DW-1:0] exp_r,
                         input logic exp_o);
        @(negedge clk);
        in_valid = 1'b1; op = o; sat_en = s; a = x; b = y; shamt = sh;
        @(posedge clk);
        #1;
        check(tag, exp_r, exp_o, 1'b1);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 reset", '0, 1'b0, 1'b0);
    endtask

    task automatic t_add;
        issue("R2 add plain", 3'd0, 1, 32'd5, 32'd7, 0, 32'd12, 0);
        issue("R2 add pos sat", 3'd0, 1, 32'h7FFFFFFF, 32'd1, 0, 32'h7FFFFFFF, 1);
        issue("R2 add neg sat", 3'd0, 1, 32'h80000000, 32'hFFFFFFFF, 0, 32'h80000000, 1);
        issue("R2 add mixed", 3'd0, 1, 32'h7FFFFFFF, 32'h80000000, 0, 32'hFFFFFFFF, 0);
        issue("R10 add wrap", 3'd0, 0, 32'h7FFFFFFF, 32'd1, 0, 32'h80000000, 1);
    endtask

    task automatic t_sub;
        issue("R3 sub neg sat", 3'd1, 1, 32'h80000000, 32'd1, 0, 32'h80000000, 1);
        issue("R3 sub pos sat", 3'd1, 1, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 32'h7FFFFFFF, 1);
        issue("R3 sub same sign", 3'd1, 1, 32'h80000000, 32'h80000000, 0, 32'd0, 0);
        issue("R10 sub wrap", 3'd1, 0, 32'h80000000, 32'd1, 0, 32'h7FFFFFFF, 1);
    endtask

    task automatic t_neg;
        issue("R4 neg plain", 3'd2, 1, 32'd5, 32'd0, 0, 32'hFFFFFFFB, 0);
        issue("R4 neg sat", 3'd2, 1, 32'h80000000, 32'd0, 0, 32'h7FFFFFFF, 1);
        issue("R4 neg wrap", 3'd2, 0, 32'h80000000, 32'd0, 0, 32'h80000000, 1);
    endtask

    task automatic t_shift;
        issue("R5 shl plain", 3'd3, 1, 32'd1, 32'd0, 4, 32'd16, 0);
        issue("R5 shl pos sat", 3'd3, 1, 32'h40000000, 32'd0, 1, 32'h7FFFFFFF, 1);
        issue("R5 shl neg ok", 3'd3, 1, 32'hC0000000, 32'd0, 1, 32'h80000000, 0);
        issue("R5 shl neg sat", 3'd3, 1, 32'hA0000000, 32'd0, 1, 32'h80000000, 1);
        issue("R5 shl wrap", 3'd3, 0, 32'hA0000000, 32'd0, 1, 32'h40000000, 1);
        issue("R5 shl max", 3'd3, 1, 32'hFFFFFFFF, 32'd0, 31, 32'h80000000, 0);
        issue("R6 shr min", 3'd4, 1, 32'h80000000, 32'd0, 31, 32'hFFFFFFFF, 0);
        issue("R6 shr pos", 3'd4, 1, 32'h00000040, 32'd0, 3, 32'd8, 0);
        issue("R7 shl zero", 3'd3, 1, 32'h92345678, 32'd0, 0, 32'h92345678, 0);
        issue("R7 shr zero", 3'd4, 1, 32'h92345678, 32'd0, 0, 32'h92345678, 0);
    endtask

    task automatic t_cls;
        issue("R8 cls zero", 3'd5, 1, 32'h00000000, 32'd0, 0, 32'd31, 0);
        issue("R8 cls ones", 3'd5, 1, 32'hFFFFFFFF, 32'd0, 0, 32'd31, 0);
        issue("R8 cls top", 3'd5, 1, 32'h40000000, 32'd0, 0, 32'd0, 0);
        issue("R8 cls min", 3'd5, 1, 32'h80000000, 32'd0, 0, 32'd0, 0);
        issue("R8 cls mid pos", 3'd5, 1, 32'h00010000, 32'd0, 0, 32'd14, 0);
        issue("R8 cls mid neg", 3'd5, 1, 32'hFFFF8000, 32'd0, 0, 32'd16, 0);
    endtask

    task automatic t_addu;
        issue("R9 addu sat", 3'd6, 1, 32'hFFFFFFFF, 32'd1, 0, 32'hFFFFFFFF, 1);
        issue("R9 addu wrap", 3'd6, 0, 32'hFFFFFFFF, 32'd1, 0, 32'd0, 1);
        issue("R9 addu fit", 3'd6, 1, 32'h80000000, 32'h7FFFFFFF, 0, 32'hFFFFFFFF, 0);
    endtask

    task automatic t_rsvd_hold;
        issue("R11 reserved", 3'd7, 1, 32'hDEADBEEF, 32'h1, 3, 32'd0, 0);
        issue("R1 set value", 3'd0, 1, 32'h7FFFFFFF, 32'd1, 0, 32'h7FFFFFFF, 1);
        @(negedge clk);
        a = 32'h1; b = 32'h1; op = 3'd0;
        @(posedge clk);
        #1;
        check("R1 idle hold", 32'h7FFFFFFF, 1'b1, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_neg();
        t_shift();
        t_cls();
        t_addu();
        t_rsvd_hold();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule